// File: doc/BRIEF.md
# Boot ROM Mapping Controller

This block decides, on every CPU memory address, whether an on-board 8K boot ROM answers the access. The CPU is 8-bit with a 16-bit address space. The ROM is seen through a 4K window at the top of memory, from F000H to FFFFH. A two-bit control register selects which 4K half of the ROM sits in that window, or takes the ROM out of the memory map. The CPU writes this register through an I/O port.

The low nibble of the port address is fixed at 3H. The high nibble comes from a board strap, so the port can be moved to avoid other peripherals. A second strap disables the on-board ROM outright. The outputs are:
- an active-low ROM chip select,
- the ROM's A12 address line, which picks the half,
- a local-access flag that steers the cycle away from the external bus.

Top module: `boot_rom_map`

## Requirements
- R1: After reset the control register holds 00H. The ROM then answers in the window with A12 low.
- R2: With the ROM enabled, `rom_cs_n_o` is low and `local_o` is high exactly when `addr_i[15:12]` is FH. Elsewhere `rom_cs_n_o` is high and `local_o` is low.
- R3: A control write whose data bit 1 is 0 (for example 00H) drives `rom_a12_o` low from the next cycle on. This selects the lower 4K of the ROM.
- R4: A control write whose data bit 1 is 1 (for example 02H) drives `rom_a12_o` high from the next cycle on. This selects the upper 4K of the ROM.
- R5: A control write whose data bit 0 is 1 (for example 01H or 03H) removes the ROM from the memory map from the next cycle on. `rom_cs_n_o` then stays high and `local_o` stays low at every address, until a later write clears bit 0.
- R6: While the strap `rom_en_i` is low, `rom_cs_n_o` is high and `local_o` is low whatever the register holds.
- R7: A control write takes effect only on a rising clock edge where all three of these hold:
  - `io_wr_i` is high,
  - `addr_i[7:4]` equals `port_nib_i`,
  - `addr_i[3:0]` equals 3H.
  
  Writes to the companion port (low nibble 2H), to another high nibble, or with the strobe low leave the register unchanged.
- R8: Address bits 15:8 take no part in the port match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 16 | CPU address bus (memory address, or I/O port number in bits 7:0) |
| io_wr_i | input | 1 | I/O write strobe, sampled on the rising edge |
| data_i | input | 8 | CPU data bus; bit 0 = ROM off, bit 1 = upper half select |
| port_nib_i | input | 4 | Strap: high nibble of the control port number |
| rom_en_i | input | 1 | Strap: on-board ROM enable |
| rom_cs_n_o | output | 1 | Active-low ROM chip select |
| rom_a12_o | output | 1 | ROM address line 12 (half select) |
| local_o | output | 1 | High when the access is served on board |

## Verification
The register has only two bits, and both are visible at the ports at once. A wrong half-select bit shows on `rom_a12_o` in the first cycle after the write that set it. A wrong off bit shows as soon as any address in the window is presented: the chip select is missing or present when it should not be. A wrong port match shows as an unchanged register after a write that should have landed, or a changed one after a write that should have been ignored. Each of those writes is therefore followed at once by a probe of the window.

// File: rtl/boot_rom_map_pkg.sv
package boot_rom_map_pkg;

   // Bit positions of the control code written by the CPU
   localparam int CTRL_OFF_BIT  = 0;
   localparam int CTRL_PAGE_BIT = 1;

   typedef struct packed {
      logic page_hi;   // selects upper half of the ROM
      logic rom_off;   // removes the ROM from the memory map
   } rom_ctrl_t;

   function automatic rom_ctrl_t code_to_ctrl(input logic [7:0] code);
      rom_ctrl_t c;
      c.page_hi = code[CTRL_PAGE_BIT];
      c.rom_off = code[CTRL_OFF_BIT];
      return c;
   endfunction

endpackage

// File: rtl/boot_rom_port_match.sv
module boot_rom_port_match #(
   parameter int          NIB_W       = 4,
   parameter logic [3:0]  PORT_LO_NIB = 4'h3,
   parameter bit          FULL_DECODE = 1'b0,
   parameter int          ADDR_W      = 16
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [NIB_W-1:0]  strap_nib_i,
   input  logic              io_wr_i,
   output logic              hit_o
);
   localparam int PORT_W = 2 * NIB_W;

   initial begin
      if (NIB_W != 4) $error("port match expects 4-bit nibbles");
      if (ADDR_W < PORT_W) $error("address narrower than port number");
   end

   logic low_ok;
   logic high_ok;
   logic upper_ok;

   assign low_ok  = (addr_i[NIB_W-1:0] == PORT_LO_NIB);
   assign high_ok = (addr_i[PORT_W-1:NIB_W] == strap_nib_i);

   generate
      if (FULL_DECODE && (ADDR_W > PORT_W)) begin : g_full
         assign upper_ok = (addr_i[ADDR_W-1:PORT_W] == '0);
      end else begin : g_partial
         logic unused_upper;
         assign unused_upper = ^addr_i;
         assign upper_ok     = 1'b1;
      end
   endgenerate

   assign hit_o = io_wr_i && low_ok && high_ok && upper_ok;
endmodule

// File: rtl/boot_rom_ctrl_reg.sv
module boot_rom_ctrl_reg
   import boot_rom_map_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter logic [7:0]  RST_CODE = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] data_i,
   output rom_ctrl_t         ctrl_o
);
   initial begin
      if (DATA_W < 2) $error("control code needs at least two bits");
   end

   logic [7:0] code_w;

   generate
      if (DATA_W >= 8) begin : g_wide
         assign code_w = data_i[7:0];
         if (DATA_W > 8) begin : g_extra
            logic unused_hi;
            assign unused_hi = ^data_i[DATA_W-1:8];
         end
      end else begin : g_narrow
         assign code_w = {{(8-DATA_W){1'b0}}, data_i};
      end
   endgenerate

   logic unused_code;
   assign unused_code = ^code_w[7:2];

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_o <= code_to_ctrl(RST_CODE);
      else if (wr_en_i)
         ctrl_o <= code_to_ctrl(code_w);
   end
endmodule

// File: rtl/boot_rom_window.sv
module boot_rom_window #(
   parameter int                ADDR_W   = 16,
   parameter int                WIN_LOG2 = 12,
   parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF000
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              in_win_o
);
   initial begin
      if (WIN_LOG2 > ADDR_W) $error("window larger than address space");
      if (WIN_LOG2 < ADDR_W && (WIN_BASE % (1 << WIN_LOG2)) != 0)
         $error("window base not aligned to its size");
   end

   generate
      if (WIN_LOG2 >= ADDR_W) begin : g_all
         logic unused_addr;
         assign unused_addr = ^addr_i;
         assign in_win_o    = 1'b1;
      end else begin : g_cmp
         logic unused_low;
         assign unused_low = ^addr_i[WIN_LOG2-1:0];
         assign in_win_o   = (addr_i[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
      end
   endgenerate
endmodule

// File: rtl/boot_rom_map.sv
module boot_rom_map
   import boot_rom_map_pkg::*;
#(
   parameter int               ADDR_W      = 16,
   parameter int               DATA_W      = 8,
   parameter int               NIB_W       = 4,
   parameter int               WIN_LOG2    = 12,
   parameter logic [15:0]      WIN_BASE    = 16'hF000,
   parameter logic [3:0]       PORT_LO_NIB = 4'h3,
   parameter bit               FULL_DECODE = 1'b0,
   parameter logic [7:0]       RST_CODE    = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              io_wr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [NIB_W-1:0]  port_nib_i,
   input  logic              rom_en_i,
   output logic              rom_cs_n_o,
   output logic              rom_a12_o,
   output logic              local_o
);
   localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(WIN_BASE);

   logic      port_hit;
   logic      in_win;
   rom_ctrl_t ctrl;
   logic      rom_sel;

   boot_rom_port_match #(
      .NIB_W      (NIB_W),
      .PORT_LO_NIB(PORT_LO_NIB),
      .FULL_DECODE(FULL_DECODE),
      .ADDR_W     (ADDR_W)
   ) u_port (
      .addr_i     (addr_i),
      .strap_nib_i(port_nib_i),
      .io_wr_i    (io_wr_i),
      .hit_o      (port_hit)
   );

   boot_rom_ctrl_reg #(
      .DATA_W  (DATA_W),
      .RST_CODE(RST_CODE)
   ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en_i(port_hit),
      .data_i (data_i),
      .ctrl_o (ctrl)
   );

   boot_rom_window #(
      .ADDR_W  (ADDR_W),
      .WIN_LOG2(WIN_LOG2),
      .WIN_BASE(BASE_W)
   ) u_win (
      .addr_i  (addr_i),
      .in_win_o(in_win)
   );

   assign rom_sel    = rom_en_i && !ctrl.rom_off && in_win;
   assign rom_cs_n_o = !rom_sel;
   assign local_o    = rom_sel;
   assign rom_a12_o  = ctrl.page_hi;
endmodule

// File: rtl/boot_rom_map_chk.sv
module boot_rom_map_chk #(
   parameter int         ADDR_W      = 16,
   parameter int         DATA_W      = 8,
   parameter int         NIB_W       = 4,
   parameter logic [3:0] PORT_LO_NIB = 4'h3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_i,
   input logic              io_wr_i,
   input logic [DATA_W-1:0] data_i,
   input logic [NIB_W-1:0]  port_nib_i,
   input logic              rom_en_i,
   input logic              rom_cs_n_o,
   input logic              rom_a12_o,
   input logic              local_o
);
   logic wr_ok;
   assign wr_ok = io_wr_i && (addr_i[7:4] == port_nib_i) && (addr_i[3:0] == PORT_LO_NIB);

   // R2: chip select only inside the top 4K
   p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_cs_n_o |-> (addr_i[15:12] == 4'hF));

   // R2: local flag and chip select agree
   p_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
      local_o != rom_cs_n_o);

   // R3: clearing bit 1 selects lower half next cycle
   p_low_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !data_i[1]) |=> !rom_a12_o);

   // R4: setting bit 1 selects upper half next cycle
   p_high_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && data_i[1]) |=> rom_a12_o);

   // R5: setting bit 0 removes ROM next cycle
   p_rom_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && data_i[0]) |=> rom_cs_n_o);

   // R6: strap disable wins
   p_strap_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_en_i |-> rom_cs_n_o);

   // R7: no qualified write, half select holds
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ok |=> $stable(rom_a12_o));
endmodule

bind boot_rom_map boot_rom_map_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .NIB_W      (NIB_W),
   .PORT_LO_NIB(PORT_LO_NIB)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr_i    (addr_i),
   .io_wr_i   (io_wr_i),
   .data_i    (data_i),
   .port_nib_i(port_nib_i),
   .rom_en_i  (rom_en_i),
   .rom_cs_n_o(rom_cs_n_o),
   .rom_a12_o (rom_a12_o),
   .local_o   (local_o)
);

// File: tb/boot_rom_map_tb.sv
module boot_rom_map_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N_VEC      = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] addr;
   logic        io_wr;
   logic [7:0]  data;
   logic [3:0]  nib;
   logic        rom_en;
   logic        cs_n, a12, loc;

   int n_run  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   boot_rom_map dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (addr),
      .io_wr_i   (io_wr),
      .data_i    (data),
      .port_nib_i(nib),
      .rom_en_i  (rom_en),
      .rom_cs_n_o(cs_n),
      .rom_a12_o (a12),
      .local_o   (loc)
   );

   // {code[7:0], probe addr[15:0], exp_cs_n, exp_a12}
   localparam logic [25:0] VEC [N_VEC] = '{
      {8'h00, 16'hF000, 1'b0, 1'b0},
      {8'h00, 16'hFFFF, 1'b0, 1'b0},
      {8'h00, 16'hEFFF, 1'b1, 1'b0},
      {8'h02, 16'hF800, 1'b0, 1'b1},
      {8'h02, 16'h0000, 1'b1, 1'b1},
      {8'h01, 16'hF000, 1'b1, 1'b0},
      {8'h01, 16'hFFFF, 1'b1, 1'b0},
      {8'h03, 16'hF123, 1'b1, 1'b1},
      {8'h00, 16'hF7FF, 1'b0, 1'b0},
      {8'h02, 16'hFFFE, 1'b0, 1'b1}
   };

   task automatic chk(input string req, input logic got, input logic exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic probe(input string req, input logic [15:0] a,
                        input logic e_cs_n, input logic e_a12);
      @(negedge clk);
      addr = a;
      #1;
      chk(req, cs_n, e_cs_n);
      chk(req, loc, !e_cs_n);
      chk(req, a12, e_a12);
   endtask

   task automatic io_write(input logic [15:0] port, input logic [7:0] d, input logic strobe);
      @(negedge clk);
      addr  = port;
      data  = d;
      io_wr = strobe;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; addr = '0; io_wr = 1'b0; data = '0; nib = 4'hD; rom_en = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      probe("R1", 16'hF000, 1'b0, 1'b0);

      // vector table: R2 R3 R4 R5
      for (int i = 0; i < N_VEC; i++) begin
         io_write(16'h00D3, VEC[i][25:18], 1'b1);
         probe("R2/R3/R4/R5 table", VEC[i][17:2], VEC[i][1], VEC[i][0]);
      end

      // R6: strap disables
      io_write(16'h00D3, 8'h00, 1'b1);
      rom_en = 1'b0;
      probe("R6", 16'hF000, 1'b1, 1'b0);
      rom_en = 1'b1;
      probe("R6", 16'hF000, 1'b0, 1'b0);

      // R7: companion port ignored
      io_write(16'h00D2, 8'h03, 1'b1);
      probe("R7 companion", 16'hF000, 1'b0, 1'b0);
      // R7: wrong nibble ignored
      io_write(16'h00C3, 8'h03, 1'b1);
      probe("R7 nibble", 16'hF000, 1'b0, 1'b0);
      // R7: strobe low ignored
      io_write(16'h00D3, 8'h03, 1'b0);
      probe("R7 strobe", 16'hF000, 1'b0, 1'b0);
      // R7: moved strap nibble
      nib = 4'hC;
      io_write(16'h00C3, 8'h02, 1'b1);
      probe("R7 strap", 16'hF000, 1'b0, 1'b1);
      nib = 4'hD;

      // R8: upper address byte ignored
      io_write(16'h55D3, 8'h01, 1'b1);
      probe("R8", 16'hF000, 1'b1, 1'b0);

      // R5: re-enable after removal
      io_write(16'hFFD3, 8'h00, 1'b1);
      probe("R5 restore", 16'hFABC, 1'b0, 1'b0);

      // R1: reset mid-run returns to 00H
      io_write(16'h00D3, 8'h03, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      probe("R1 rerun", 16'hF000, 1'b0, 1'b0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule